// File: doc/BRIEF.md
# Block Engine Ring Sequencer

This block keeps track of a circular set of block engines, each of which runs one fixed-length block of instructions at a time. A block supplier offers blocks through a valid/ready handshake. The sequencer places each accepted block on the next free engine in ring order. It marks the oldest occupied engine as the only one running non-speculatively. It frees engines strictly in age order, one whole block at a time. When an engine reports that its block left through a mispredicted exit branch, every younger engine is freed, and new blocks are then placed after the engine that mispredicted.

The state is a head index and an occupancy count. The tail index is derived from them. For every engine the sequencer also tracks a start-up sequence of three cycles (dispatch, register read, first selection), so that `run` tells the engine when it may issue. It also remembers a completion report that arrives before the engine reaches the head, so that report is not lost.

Top module: `blk_ring_seq`

## Requirements
- R1: Once reset is released, head is 0, occupancy is 0, tail reads NUM_ENG-1, `disp_ready` is 1, and `nonspec`, `run`, `assign_eng` and `clear_eng` are all zero.
- R2: In a cycle with `disp_valid` and `disp_ready` both high, `assign_eng` is one-hot on engine (head + occupancy) mod NUM_ENG and `assign_id` equals `disp_id`. Occupancy then rises by one at the next edge. At most one block is placed per cycle, so an empty ring of NUM_ENG engines needs NUM_ENG cycles to fill.
- R3: `disp_ready` is low whenever occupancy equals NUM_ENG. In that case no engine is assigned.
- R4: `nonspec` is one-hot on the head engine whenever occupancy is non-zero, and all zero when the ring is empty.
- R5: `tail_idx` equals (head + occupancy - 1) mod NUM_ENG. When the ring is empty this is the engine just before the head.
- R6: An engine's block retires only once its `done` bit has been seen while the engine is occupied, and only from the head. When the head has finished (reported now or in an earlier cycle), the head advances by one (mod NUM_ENG) and occupancy falls by one. A `done` from a younger engine is held until that engine becomes the head.
- R7: If `mispredict` is set for occupied engines, only the oldest of them counts. Call its age offset from the head k. In that cycle `clear_eng` pulses for the engines at offsets k+1 up to occupancy-1, `disp_ready` is low, and occupancy becomes k+1. The mispredicting engine itself is kept.
- R8: `run[e]` goes high in the third cycle after the cycle in which engine e was assigned. It stays high until e is retired or cleared.
- R9: `done` and `mispredict` bits of unoccupied engines have no effect.
- R10: A head retirement and a misprediction in the same cycle both take effect. Occupancy becomes k+1-1 and the head advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_valid | input | 1 | A fetched block is offered |
| disp_id | input | ID_W | Identifier of the offered block |
| disp_ready | output | 1 | Sequencer accepts the offered block this cycle |
| done | input | NUM_ENG | Per-engine: block fully executed |
| mispredict | input | NUM_ENG | Per-engine: exit branch was mispredicted |
| assign_eng | output | NUM_ENG | One-hot pulse: engine receiving the accepted block |
| assign_id | output | ID_W | Identifier handed to the assigned engine |
| clear_eng | output | NUM_ENG | Pulse: engine squashed by a misprediction |
| nonspec | output | NUM_ENG | Engine running non-speculatively (head) |
| run | output | NUM_ENG | Engine past start-up and allowed to issue |
| head_idx | output | $clog2(NUM_ENG) | Oldest occupied engine |
| tail_idx | output | $clog2(NUM_ENG) | Youngest occupied engine |
| occ_cnt | output | $clog2(NUM_ENG+1) | Number of occupied engines |

## Verification
Several properties are checked on every cycle:
- at most one engine is non-speculative, and exactly one whenever the ring is occupied;
- assignments are one-hot and never coincide with a squash;
- no assignment happens when the ring is full;
- the head only ever steps by one;
- `run` only rises three cycles after an assignment.

Other behaviour can only be shown by the bench's scenarios, where a reference model tracks head, occupancy, held completions and start-up stages:
- which engines a misprediction clears when several engines mispredict at once;
- that an early completion is held back until its engine reaches the head;
- how retirement and squash combine in one cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [1:0] {
      STG_IDLE   = 2'd0,
      STG_REGRD  = 2'd1,
      STG_SELECT = 2'd2,
      STG_RUN    = 2'd3
   } stg_t;

   // a and b both below n, or b at most n: single wrap is enough
   function automatic int ring_add(int a, int b, int n);
      int s;
      s = a + b;
      return (s >= n) ? s - n : s;
   endfunction

   // age distance from index 'from' forward to index 'to'
   function automatic int ring_dist(int from, int to, int n);
      return (to >= from) ? to - from : to + n - from;
   endfunction

endpackage

// File: rtl/seq_ring_ptr.sv
module seq_ring_ptr #(
   parameter int NUM_ENG = 4,
   localparam int IDX_W = $clog2(NUM_ENG),
   localparam int CNT_W = $clog2(NUM_ENG + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             retire,
   input  logic             cut,
   input  logic [IDX_W-1:0] cut_off,
   output logic [IDX_W-1:0] head,
   output logic [CNT_W-1:0] count
);

   logic [IDX_W-1:0] head_inc;
   logic [CNT_W-1:0] count_d;

   generate
      if ((NUM_ENG & (NUM_ENG - 1)) == 0) begin : g_pow2
         assign head_inc = head + IDX_W'(1);
      end else begin : g_gen
         assign head_inc = (head == IDX_W'(NUM_ENG - 1)) ? '0 : head + IDX_W'(1);
      end
   endgenerate

   always_comb begin
      int base;
      base = cut ? int'(cut_off) + 1 : int'(count);
      base = base - (retire ? 1 : 0) + (fire ? 1 : 0);
      count_d = CNT_W'(base);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         count <= '0;
      end else begin
         count <= count_d;
         if (retire) head <= head_inc;
      end
   end

endmodule

// File: rtl/seq_misp_pick.sv
module seq_misp_pick
   import seq_pkg::*;
#(
   parameter int NUM_ENG = 4,
   localparam int IDX_W = $clog2(NUM_ENG),
   localparam int CNT_W = $clog2(NUM_ENG + 1)
) (
   input  logic [NUM_ENG-1:0] misp,
   input  logic [IDX_W-1:0]   head,
   input  logic [CNT_W-1:0]   count,
   output logic               cut,
   output logic [IDX_W-1:0]   cut_off,
   output logic [NUM_ENG-1:0] kill
);

   always_comb begin
      logic found;
      int   pos;
      found = 1'b0;
      pos   = 0;
      for (int k = 0; k < NUM_ENG; k++) begin
         if (!found && k < int'(count) && misp[ring_add(int'(head), k, NUM_ENG)]) begin
            found = 1'b1;
            pos   = k;
         end
      end
      cut     = found;
      cut_off = IDX_W'(pos);
      for (int e = 0; e < NUM_ENG; e++) begin
         int d;
         d = ring_dist(int'(head), e, NUM_ENG);
         kill[e] = found && (d > pos) && (d < int'(count));
      end
   end

endmodule

// File: rtl/seq_eng_slot.sv
module seq_eng_slot
   import seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic occ,
   input  logic go,
   input  logic kill,
   input  logic done_in,
   output logic fin,
   output logic run
);

   stg_t stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= STG_IDLE;
         fin <= 1'b0;
      end else if (kill) begin
         stg <= STG_IDLE;
         fin <= 1'b0;
      end else begin
         if (go) begin
            stg <= STG_REGRD;
         end else begin
            case (stg)
               STG_REGRD:  stg <= STG_SELECT;
               STG_SELECT: stg <= STG_RUN;
               default:    stg <= stg;
            endcase
         end
         if (occ && done_in) fin <= 1'b1;
      end
   end

   assign run = (stg == STG_RUN);

endmodule

// File: rtl/blk_ring_seq.sv
module blk_ring_seq
   import seq_pkg::*;
#(
   parameter int NUM_ENG = 4,
   parameter int ID_W    = 8,
   localparam int IDX_W  = $clog2(NUM_ENG),
   localparam int CNT_W  = $clog2(NUM_ENG + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               disp_valid,
   input  logic [ID_W-1:0]    disp_id,
   output logic               disp_ready,
   input  logic [NUM_ENG-1:0] done,
   input  logic [NUM_ENG-1:0] mispredict,
   output logic [NUM_ENG-1:0] assign_eng,
   output logic [ID_W-1:0]    assign_id,
   output logic [NUM_ENG-1:0] clear_eng,
   output logic [NUM_ENG-1:0] nonspec,
   output logic [NUM_ENG-1:0] run,
   output logic [IDX_W-1:0]   head_idx,
   output logic [IDX_W-1:0]   tail_idx,
   output logic [CNT_W-1:0]   occ_cnt
);

   generate
      if (NUM_ENG < 2) begin : g_bad_eng
         $error("blk_ring_seq: NUM_ENG must be at least 2");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("blk_ring_seq: ID_W must be at least 1");
      end
   endgenerate

   logic [IDX_W-1:0]   head;
   logic [CNT_W-1:0]   count;
   logic               cut;
   logic [IDX_W-1:0]   cut_off;
   logic [NUM_ENG-1:0] kill_vec;
   logic [NUM_ENG-1:0] occ_vec;
   logic [NUM_ENG-1:0] fin_vec;
   logic [IDX_W-1:0]   slot;
   logic               fire;
   logic               retire;

   seq_misp_pick #(.NUM_ENG(NUM_ENG)) u_pick (
      .misp    (mispredict),
      .head    (head),
      .count   (count),
      .cut     (cut),
      .cut_off (cut_off),
      .kill    (kill_vec)
   );

   assign disp_ready = (count != CNT_W'(NUM_ENG)) && !cut;
   assign fire       = disp_valid && disp_ready;
   assign slot       = IDX_W'(ring_add(int'(head), int'(count), NUM_ENG));
   assign retire     = (count != '0) && (fin_vec[head] || done[head]);

   always_comb begin
      for (int e = 0; e < NUM_ENG; e++) begin
         occ_vec[e]    = ring_dist(int'(head), e, NUM_ENG) < int'(count);
         assign_eng[e] = fire && (int'(slot) == e);
         nonspec[e]    = (count != '0) && (int'(head) == e);
      end
   end

   seq_ring_ptr #(.NUM_ENG(NUM_ENG)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire),
      .retire  (retire),
      .cut     (cut),
      .cut_off (cut_off),
      .head    (head),
      .count   (count)
   );

   for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
      seq_eng_slot u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .occ     (occ_vec[g]),
         .go      (assign_eng[g]),
         .kill    (kill_vec[g] || (retire && (int'(head) == g))),
         .done_in (done[g]),
         .fin     (fin_vec[g]),
         .run     (run[g])
      );
   end

   assign clear_eng = kill_vec;
   assign assign_id = disp_id;
   assign head_idx  = head;
   assign tail_idx  = IDX_W'(ring_add(int'(head),
                         (count == '0) ? NUM_ENG - 1 : int'(count) - 1, NUM_ENG));
   assign occ_cnt   = count;

endmodule

// File: rtl/blk_ring_seq_chk.sv
module blk_ring_seq_chk #(
   parameter int NUM_ENG = 4,
   parameter int ID_W    = 8,
   localparam int IDX_W  = $clog2(NUM_ENG),
   localparam int CNT_W  = $clog2(NUM_ENG + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               disp_valid,
   input logic [ID_W-1:0]    disp_id,
   input logic               disp_ready,
   input logic [NUM_ENG-1:0] done,
   input logic [NUM_ENG-1:0] mispredict,
   input logic [NUM_ENG-1:0] assign_eng,
   input logic [ID_W-1:0]    assign_id,
   input logic [NUM_ENG-1:0] clear_eng,
   input logic [NUM_ENG-1:0] nonspec,
   input logic [NUM_ENG-1:0] run,
   input logic [IDX_W-1:0]   head_idx,
   input logic [IDX_W-1:0]   tail_idx,
   input logic [CNT_W-1:0]   occ_cnt
);

   // R4
   nonspec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(nonspec) && ((occ_cnt != '0) == ($countones(nonspec) == 1)));

   // R2
   assign_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(assign_eng) && (occ_cnt <= CNT_W'(NUM_ENG)));

   // R3
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_cnt == CNT_W'(NUM_ENG)) |-> (!disp_ready && assign_eng == '0));

   // R7
   squash_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_eng != '0) |-> (assign_eng == '0 && !disp_ready));

   // R6
   head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (head_idx != $past(head_idx)) |->
         (int'(head_idx) == (int'($past(head_idx)) + 1) % NUM_ENG));

   // R2
   occ_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_cnt > $past(occ_cnt)) |-> ($past(assign_eng) != '0));

   for (genvar g = 0; g < NUM_ENG; g++) begin : g_run
      // R8
      run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(run[g]) |-> $past(assign_eng[g], 3));
   end

endmodule

bind blk_ring_seq blk_ring_seq_chk #(.NUM_ENG(NUM_ENG), .ID_W(ID_W)) i_chk (.*);

// File: tb/test_blk_ring_seq.sv
module test_blk_ring_seq;

   localparam int N    = 4;
   localparam int IDW  = 8;
   localparam int IW   = $clog2(N);
   localparam int CW   = $clog2(N + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          disp_valid = 1'b0;
   logic [IDW-1:0] disp_id = '0;
   logic          disp_ready;
   logic [N-1:0]  done = '0;
   logic [N-1:0]  mispredict = '0;
   logic [N-1:0]  assign_eng, clear_eng, nonspec, run;
   logic [IDW-1:0] assign_id;
   logic [IW-1:0] head_idx, tail_idx;
   logic [CW-1:0] occ_cnt;

   int n_chk = 0;
   int n_bad = 0;
   int mh = 0;
   int mc = 0;
   int mfin[N];
   int mstg[N];

   always #10 clk = ~clk;

   blk_ring_seq #(.NUM_ENG(N), .ID_W(IDW)) i_blk_ring_seq (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_id(disp_id),
      .disp_ready(disp_ready), .done(done), .mispredict(mispredict),
      .assign_eng(assign_eng), .assign_id(assign_id), .clear_eng(clear_eng),
      .nonspec(nonspec), .run(run), .head_idx(head_idx), .tail_idx(tail_idx),
      .occ_cnt(occ_cnt)
   );

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic chk_state();
      int ns, rn;
      ns = 0;
      rn = 0;
      if (mc > 0) ns = 1 << mh;
      for (int e = 0; e < N; e++) if (mstg[e] == 3) rn |= (1 << e);
      chk("R6", "head", int'(head_idx), mh);
      chk("R2", "occupancy", int'(occ_cnt), mc);
      chk("R5", "tail", int'(tail_idx), (mh + mc + N - 1) % N);
      chk("R4", "nonspec", int'(nonspec), ns);
      chk("R8", "run", int'(run), rn);
   endtask

   // one cycle: drive at negedge, check comb outputs, advance the model
   task automatic cycle(bit v, int id, int dn, int mp);
      int  h, c, koff, slot, ea, ec;
      bit  hit, rdy, fire, ret;
      h = mh;
      c = mc;
      disp_valid = v;
      disp_id    = IDW'(id);
      done       = N'(dn);
      mispredict = N'(mp);
      #2;
      hit  = 0;
      koff = 0;
      for (int k = 0; k < c; k++)
         if (!hit && mp[(h + k) % N]) begin hit = 1; koff = k; end
      rdy  = (c < N) && !hit;
      fire = v && rdy;
      slot = (h + c) % N;
      ea   = fire ? (1 << slot) : 0;
      ec   = 0;
      for (int e = 0; e < N; e++) begin
         int d;
         d = (e - h + N) % N;
         if (hit && d > koff && d < c) ec |= (1 << e);
      end
      ret = (c > 0) && (mfin[h] != 0 || dn[h]);
      chk(hit ? "R7" : "R3", "ready", int'(disp_ready), int'(rdy));
      chk("R2", "assign", int'(assign_eng), ea);
      if (fire) chk("R2", "assign_id", int'(assign_id), id);
      chk(ret && hit ? "R10" : "R7", "clear", int'(clear_eng), ec);
      for (int e = 0; e < N; e++) begin
         bit occ;
         occ = ((e - h + N) % N) < c;
         if (ec[e] || (ret && e == h)) begin
            mfin[e] = 0;
            mstg[e] = 0;
         end else begin
            if (fire && e == slot) mstg[e] = 1;
            else if (mstg[e] == 1 || mstg[e] == 2) mstg[e]++;
            if (occ && dn[e]) mfin[e] = 1;
         end
      end
      mc = (hit ? koff + 1 : c) - (ret ? 1 : 0) + (fire ? 1 : 0);
      mh = ret ? (h + 1) % N : h;
      @(negedge clk);
      chk_state();
   endtask

   initial begin
      #3000000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int e = 0; e < N; e++) begin mfin[e] = 0; mstg[e] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "head", int'(head_idx), 0);
      chk("R1", "occupancy", int'(occ_cnt), 0);
      chk("R1", "tail", int'(tail_idx), N - 1);
      chk("R1", "ready", int'(disp_ready), 1);
      chk("R1", "outputs", int'({nonspec, run, assign_eng, clear_eng}), 0);
      // R9: events on an empty ring do nothing
      cycle(0, 0, 4'hF, 4'hF);
      // R2/R3: fill takes N cycles, then ready drops
      for (int i = 0; i < N + 1; i++) cycle(1, 16 + i, 0, 0);
      // R8: let start-up finish
      cycle(0, 0, 0, 0);
      cycle(0, 0, 0, 0);
      // R6: early done at engine 2 held, then head retires 0,1,2
      cycle(0, 0, 4'b0100, 0);
      cycle(0, 0, 4'b0001, 0);
      cycle(0, 0, 4'b0010, 0);
      cycle(0, 0, 0, 0);
      // refill, then R7: mispredict from two engines, oldest wins
      for (int i = 0; i < 3; i++) cycle(1, 40 + i, 0, 0);
      cycle(1, 50, 0, 4'b0011);
      // R10: head done with mispredict at head
      cycle(1, 51, 1 << mh, 1 << mh);
      // R9 and general mix: random sweep
      for (int i = 0; i < 4000; i++) begin
         int dn, mp;
         dn = 0;
         mp = 0;
         for (int e = 0; e < N; e++) begin
            if ($urandom_range(0, 99) < 18) dn |= (1 << e);
            if ($urandom_range(0, 99) < 6) mp |= (1 << e);
         end
         cycle($urandom_range(0, 99) < 70, int'($urandom_range(0, 255)), dn, mp);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule